// File: doc/BRIEF.md
# Tag Propagation Engine

This block is a small execution unit that tracks information-flow labels rather than data. Every architectural register has a 4-bit security tag, and a tag memory shadows data memory one word per address. A stream of tag micro-instructions arrives on a valid/ready interface. Each one carries an opcode, register indices, an address that has already been computed and an immediate tag. The engine moves, merges, seeds and inspects tags to follow the flow of information through a program.

Arithmetic-style operations merge their source tags by bitwise union. Load and store forms copy tags between the register tags and the tag memory. Initialise forms set a tag directly. A check form tests a register tag against a programmable policy mask. A hit raises a violation flag, and the flag stays up until an explicit clear instruction. Each accepted instruction reports its resulting tag one cycle later on a result port, so the whole tag state can be observed through the normal instruction flow.

Top module: `tag_prop_engine`

## Requirements
- R1: After reset all register tags read as zero, the violation flag is low, res_valid is low and the policy mask is zero.
- R2: Opcode 1 (merge) sets the tag of register rd to the bitwise OR of the tags of rs1 and rs2. That value appears on res_tag, with res_valid high, in the cycle after acceptance.
- R3: Opcode 2 (load) sets the tag of rd to the tag memory word at in_addr, and reports that word on res_tag one cycle after acceptance.
- R4: Opcode 3 (store) writes the tag of rs1 into the tag memory word at in_addr and reports the stored tag. Any later load from that address returns it.
- R5: Opcode 4 sets the tag of rd to in_tag, and opcode 5 writes in_tag into the tag memory word at in_addr. Both report in_tag.
- R6: Opcode 6 (check) reports the tag of rs1. It raises violation in the cycle after acceptance when that tag ANDed with the policy mask is nonzero, and leaves violation unchanged otherwise.
- R7: Once raised, violation stays high through any other instructions until opcode 8 (clear) is accepted. Clear drops violation the next cycle and reports tag 0.
- R8: Opcode 7 loads in_tag into the policy mask and reports it. The new mask applies to every check accepted afterwards.
- R9: in_ready is always high and one instruction is taken per cycle. An instruction that reads a register written by the one just before it, including a load, sees the new tag without any stall.
- R10: The tag memory holds 256 words addressed by in_addr. Addresses 0 and 255 are independent words.
- R11: Opcode 0 and opcodes 9 to 15 change no tag, no policy and no violation state, and produce no result (res_valid low). Cycles with in_valid low behave the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Micro-instruction present |
| in_ready | output | 1 | Engine can accept (always high) |
| in_op | input | 4 | Opcode |
| in_rd | input | 4 | Destination register index |
| in_rs1 | input | 4 | First source register index |
| in_rs2 | input | 4 | Second source register index |
| in_addr | input | 8 | Tag memory word address |
| in_tag | input | 4 | Immediate tag for initialise and policy forms |
| res_valid | output | 1 | Result of the instruction accepted last cycle |
| res_tag | output | 4 | Tag produced or inspected by that instruction |
| violation | output | 1 | Sticky policy violation flag |

## Verification
A corrupted register tag or memory word stays hidden until an instruction reads it. It then shows up on res_tag one cycle after the reading instruction, and it also spreads into every tag derived from it. For that reason the random phase chains merges, loads and stores through a small register and address set, so stale state is read soon after it is written. A wrong forwarding path shows on the very next result when a dependent instruction follows a writer back to back. A wrong policy or violation state shows on the violation pin one cycle after a check or clear.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_MERGE  = 4'd1,
    OP_LOAD   = 4'd2,
    OP_STORE  = 4'd3,
    OP_SETR   = 4'd4,
    OP_SETM   = 4'd5,
    OP_CHECK  = 4'd6,
    OP_POLICY = 4'd7,
    OP_CLEAR  = 4'd8
  } tpe_op_e;
endpackage

// File: rtl/tpe_regfile.sv
module tpe_regfile #(
  parameter int NREG  = 16,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [TAG_W-1:0] wdata,
  input  logic [IDX_W-1:0] ra_a,
  input  logic [IDX_W-1:0] ra_b,
  output logic [TAG_W-1:0] rd_a,
  output logic [TAG_W-1:0] rd_b
);
  logic [TAG_W-1:0] tags   [NREG];
  logic [TAG_W-1:0] tags_d [NREG];
  logic [NREG-1:0]  hit;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    assign hit[i] = we && (waddr == MY_IDX);
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      tags_d[i] = hit[i] ? wdata : tags[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) tags[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) tags[i] <= tags_d[i];
    end
  end

  assign rd_a = tags[ra_a];
  assign rd_b = tags[ra_b];

  // R2: a register write is held in the file afterwards
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> tags[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/tpe_tagmem.sv
module tpe_tagmem #(
  parameter int DEPTH = 256,
  parameter int TAG_W = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [TAG_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [TAG_W-1:0] rdata
);
  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  // R4: a read right after a write to the same word returns the written tag
  p_store_then_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we ##1 (re && raddr == $past(waddr)) |=> rdata == $past(wdata, 2));
endmodule

// File: rtl/tpe_guard.sv
module tpe_guard #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pol_we,
  input  logic [TAG_W-1:0] pol_wdata,
  input  logic             chk_en,
  input  logic [TAG_W-1:0] chk_tag,
  input  logic             clr,
  output logic             violation
);
  logic [TAG_W-1:0] policy, policy_d;
  logic             viol_d;

  always_comb begin
    policy_d = pol_we ? pol_wdata : policy;
    viol_d   = violation;
    if (clr) viol_d = 1'b0;
    if (chk_en && |(chk_tag & policy)) viol_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      policy    <= '0;
      violation <= 1'b0;
    end else begin
      policy    <= policy_d;
      violation <= viol_d;
    end
  end

  // R6: a check that hits the mask raises the flag
  p_check_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && (chk_tag & policy) != '0) |=> violation);
  // R7: the flag holds until cleared
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (violation && !clr) |=> violation);
  // R7: clear without a concurrent check drops the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !chk_en) |=> !violation);
endmodule

// File: rtl/tag_prop_engine.sv
module tag_prop_engine
  import tpe_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int TAG_W     = 4,
  parameter int MEM_DEPTH = 256,
  localparam int RIDX_W = $clog2(NREG),
  localparam int MAW    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [RIDX_W-1:0] in_rd,
  input  logic [RIDX_W-1:0] in_rs1,
  input  logic [RIDX_W-1:0] in_rs2,
  input  logic [MAW-1:0]    in_addr,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_tag,
  output logic              violation
);
  tpe_op_e op;
  logic    acc;

  // second stage (write-back) state
  logic              s2_valid, s2_wr, s2_ld;
  logic [RIDX_W-1:0] s2_rd;
  logic [TAG_W-1:0]  s2_val;
  logic              s2_valid_d, s2_wr_d, s2_ld_d;
  logic [TAG_W-1:0]  s2_val_d;

  logic [TAG_W-1:0]  rf_a, rf_b, src_a, src_b, mem_q, wb_data;
  logic              wb_we;
  logic              mem_we, mem_re, pol_we, chk_en, clr;
  logic [TAG_W-1:0]  mem_wdata;

  assign in_ready = 1'b1;
  assign acc      = in_valid;
  assign op       = tpe_op_e'(in_op);

  // write-back data and bypass into the read stage
  assign wb_we   = s2_valid && s2_wr;
  assign wb_data = s2_ld ? mem_q : s2_val;
  assign src_a   = (wb_we && s2_rd == in_rs1) ? wb_data : rf_a;
  assign src_b   = (wb_we && s2_rd == in_rs2) ? wb_data : rf_b;

  always_comb begin
    s2_valid_d = 1'b0;
    s2_wr_d    = 1'b0;
    s2_ld_d    = 1'b0;
    s2_val_d   = '0;
    mem_we     = 1'b0;
    mem_re     = 1'b0;
    mem_wdata  = src_a;
    pol_we     = 1'b0;
    chk_en     = 1'b0;
    clr        = 1'b0;
    if (acc) begin
      case (op)
        OP_MERGE:  begin s2_valid_d = 1'b1; s2_wr_d = 1'b1; s2_val_d = src_a | src_b; end
        OP_LOAD:   begin s2_valid_d = 1'b1; s2_wr_d = 1'b1; s2_ld_d = 1'b1; mem_re = 1'b1; end
        OP_STORE:  begin s2_valid_d = 1'b1; s2_val_d = src_a; mem_we = 1'b1; end
        OP_SETR:   begin s2_valid_d = 1'b1; s2_wr_d = 1'b1; s2_val_d = in_tag; end
        OP_SETM:   begin s2_valid_d = 1'b1; s2_val_d = in_tag; mem_we = 1'b1; mem_wdata = in_tag; end
        OP_CHECK:  begin s2_valid_d = 1'b1; s2_val_d = src_a; chk_en = 1'b1; end
        OP_POLICY: begin s2_valid_d = 1'b1; s2_val_d = in_tag; pol_we = 1'b1; end
        OP_CLEAR:  begin s2_valid_d = 1'b1; clr = 1'b1; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_wr    <= 1'b0;
      s2_ld    <= 1'b0;
      s2_rd    <= '0;
      s2_val   <= '0;
    end else begin
      s2_valid <= s2_valid_d;
      s2_wr    <= s2_wr_d;
      s2_ld    <= s2_ld_d;
      if (acc) begin
        s2_rd  <= in_rd;
        s2_val <= s2_val_d;
      end
    end
  end

  tpe_regfile #(.NREG(NREG), .TAG_W(TAG_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(wb_we), .waddr(s2_rd), .wdata(wb_data),
    .ra_a(in_rs1), .ra_b(in_rs2), .rd_a(rf_a), .rd_b(rf_b)
  );

  tpe_tagmem #(.DEPTH(MEM_DEPTH), .TAG_W(TAG_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .waddr(in_addr), .wdata(mem_wdata),
    .re(mem_re), .raddr(in_addr), .rdata(mem_q)
  );

  tpe_guard #(.TAG_W(TAG_W)) u_guard (
    .clk(clk), .rst_n(rst_n),
    .pol_we(pol_we), .pol_wdata(in_tag),
    .chk_en(chk_en), .chk_tag(src_a), .clr(clr),
    .violation(violation)
  );

  assign res_valid = s2_valid;
  assign res_tag   = wb_data;

  // R9: every accepted known operation yields a result next cycle
  p_result_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op >= 4'd1 && in_op <= 4'd8) |=> res_valid);
  // R11: idle cycles and no-op codes produce no result
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || in_op == 4'd0 || in_op > 4'd8) |=> !res_valid);
endmodule

// File: tb/tag_prop_engine_test.sv
module tag_prop_engine_test;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       in_valid, in_ready;
  logic [3:0] in_op, in_rd, in_rs1, in_rs2, in_tag;
  logic [7:0] in_addr;
  logic       res_valid, violation;
  logic [3:0] res_tag;

  int n_vec  = 0;
  int n_fail = 0;

  logic [3:0] m_reg [16];
  logic [3:0] m_mem [256];
  logic [3:0] m_pol;
  logic       m_viol;
  logic       exp_valid;
  logic [3:0] exp_tag;
  string      exp_req;

  tag_prop_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_addr(in_addr), .in_tag(in_tag), .res_valid(res_valid),
    .res_tag(res_tag), .violation(violation)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    check_bit(exp_valid ? "R9 res_valid" : "R11 res_valid", res_valid, exp_valid);
    if (exp_valid) begin
      n_vec++;
      if (res_tag !== exp_tag) begin
        n_fail++;
        $display("FAIL %s: res_tag actual %h expected %h at %0t", exp_req, res_tag, exp_tag, $time);
      end
    end
    check_bit("R7 violation", violation, m_viol);
    check_bit("R9 in_ready", in_ready, 1'b1);
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] rd, input logic [3:0] rs1,
                       input logic [3:0] rs2, input logic [7:0] addr, input logic [3:0] tag);
    logic [3:0] t;
    @(negedge clk);
    compare();
    in_valid = 1'b1; in_op = op; in_rd = rd; in_rs1 = rs1; in_rs2 = rs2;
    in_addr = addr; in_tag = tag;
    exp_valid = 1'b1;
    case (op)
      4'd1: begin t = m_reg[rs1] | m_reg[rs2]; m_reg[rd] = t; exp_tag = t; exp_req = "R2 merge"; end
      4'd2: begin t = m_mem[addr]; m_reg[rd] = t; exp_tag = t; exp_req = "R3 load"; end
      4'd3: begin t = m_reg[rs1]; m_mem[addr] = t; exp_tag = t; exp_req = "R4 store"; end
      4'd4: begin m_reg[rd] = tag; exp_tag = tag; exp_req = "R5 set reg"; end
      4'd5: begin m_mem[addr] = tag; exp_tag = tag; exp_req = "R5 set mem"; end
      4'd6: begin
        t = m_reg[rs1]; exp_tag = t; exp_req = "R6 check";
        if ((t & m_pol) != 4'd0) m_viol = 1'b1;
      end
      4'd7: begin m_pol = tag; exp_tag = tag; exp_req = "R8 policy"; end
      4'd8: begin m_viol = 1'b0; exp_tag = 4'd0; exp_req = "R7 clear"; end
      default: begin exp_valid = 1'b0; exp_req = "R11 no-op"; end
    endcase
  endtask

  task automatic idle();
    @(negedge clk);
    compare();
    in_valid = 1'b0;
    in_op = $urandom_range(15, 0);
    exp_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = 4'd0;
    for (int i = 0; i < 256; i++) m_mem[i] = 4'd0;
    m_pol = 4'd0; m_viol = 1'b0; exp_valid = 1'b0; exp_tag = 4'd0; exp_req = "R1";
    rst_n = 1'b0; in_valid = 1'b0; in_op = 4'd0; in_rd = 4'd0; in_rs1 = 4'd0;
    in_rs2 = 4'd0; in_addr = 8'd0; in_tag = 4'd0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check_bit("R1 res_valid", res_valid, 1'b0);
    check_bit("R1 violation", violation, 1'b0);
    rst_n = 1'b1;

    // R1: register tags start at zero
    issue(4'd1, 4'd1, 4'd2, 4'd3, 8'd0, 4'd0);
    // R1: zero policy flags nothing
    issue(4'd4, 4'd9, 4'd0, 4'd0, 8'd0, 4'hF);
    issue(4'd6, 4'd0, 4'd9, 4'd0, 8'd0, 4'd0);
    // seed every tag memory word (R5, R10)
    for (int a = 0; a < 256; a++) issue(4'd5, 4'd0, 4'd0, 4'd0, 8'(a), 4'(a * 7 + 3));
    // R2 with back-to-back forwarding (R9)
    issue(4'd4, 4'd1, 4'd0, 4'd0, 8'd0, 4'h3);
    issue(4'd4, 4'd2, 4'd0, 4'd0, 8'd0, 4'h4);
    issue(4'd1, 4'd3, 4'd1, 4'd2, 8'd0, 4'd0);
    // R4 then R3 then dependent merge on the loaded tag (R9)
    issue(4'd3, 4'd0, 4'd3, 4'd0, 8'h10, 4'd0);
    issue(4'd2, 4'd5, 4'd0, 4'd0, 8'h10, 4'd0);
    issue(4'd1, 4'd6, 4'd5, 4'd0, 8'd0, 4'd0);
    // R10: address corners are separate words
    issue(4'd5, 4'd0, 4'd0, 4'd0, 8'h00, 4'hA);
    issue(4'd5, 4'd0, 4'd0, 4'd0, 8'hFF, 4'h5);
    issue(4'd2, 4'd7, 4'd0, 4'd0, 8'h00, 4'd0);
    issue(4'd2, 4'd8, 4'd0, 4'd0, 8'hFF, 4'd0);
    // R8 / R6: policy then check miss and hit
    issue(4'd7, 4'd0, 4'd0, 4'd0, 8'd0, 4'h8);
    issue(4'd6, 4'd0, 4'd3, 4'd0, 8'd0, 4'd0);
    issue(4'd4, 4'd11, 4'd0, 4'd0, 8'd0, 4'h8);
    issue(4'd6, 4'd0, 4'd11, 4'd0, 8'd0, 4'd0);
    // R7: sticky through other work and no-ops (R11)
    issue(4'd6, 4'd0, 4'd3, 4'd0, 8'd0, 4'd0);
    issue(4'd12, 4'd3, 4'd11, 4'd11, 8'h10, 4'hF);
    idle();
    issue(4'd1, 4'd12, 4'd3, 4'd3, 8'd0, 4'd0);
    issue(4'd8, 4'd0, 4'd0, 4'd0, 8'd0, 4'd0);
    issue(4'd0, 4'd3, 4'd0, 4'd0, 8'd0, 4'hF);
    issue(4'd1, 4'd13, 4'd3, 4'd0, 8'd0, 4'd0);

    // random mix over a narrow register and address set
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(9, 0) == 0) idle();
      else issue(4'($urandom_range(15, 0)), 4'($urandom_range(5, 0)), 4'($urandom_range(5, 0)),
                 4'($urandom_range(5, 0)), 8'($urandom_range(3, 0) * 85), 4'($urandom_range(15, 0)));
    end
    idle();
    idle();

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule